// File: doc/BRIEF.md
# Dual-Bank OUT Endpoint Receive Buffer

This block holds the receive buffers of a single device-side OUT endpoint. Packet bytes arrive from the bus side with start, valid and end strobes. Each packet is written into a free bank and answered with an ACK pulse. If no bank is free, the packet is thrown away and answered with a NAK pulse. A configuration input selects one bank or two. With two banks, the host can fill one bank while the CPU drains the other. The writer and the reader each step through bank 0 and bank 1 in turn.

On the CPU side there are two bits with separate jobs. The receive flag is the interrupt source, and software acknowledges it by clearing it. The ownership bit means the CPU holds the current bank, and software hands the bank back by clearing it with a separate release strobe. While the CPU holds a bank, a down-counting byte count and a read-allowed bit go with a byte-wide read port.

For an isochronous IN direction, the block also answers an IN request that finds no filled bank. It sends a zero-length packet and raises an underflow flag, which can drive the endpoint interrupt.

Top module: `ep_rxb_ctrl`

## Requirements
- R1: After reset, every flag is 0, the byte count is 0, read-allowed is 0, the interrupt is low and no ACK, NAK or zero-length pulse is driven.
- R2: A packet that starts while the writer's bank is free is stored. `hs_ack` pulses for one cycle in the cycle after `pkt_end`. In the cycle after that, `rx_flag` and `own_flag` are 1 and `byte_cnt` equals the packet length. The end strobe carries no data byte.
- R3: `ep_irq` is 1 exactly when (`rx_flag` and `cpu_rx_ie`) or (`uf_flag` and `cpu_uf_ie`).
- R4: A `cpu_clr_rx` strobe clears `rx_flag` on the next edge and leaves `own_flag` and `byte_cnt` unchanged.
- R5: A `cpu_rd` strobe while `rd_allowed` is 1 does three things on the next edge. It puts the next stored byte on `rd_data`, with bytes in arrival order. It lowers `byte_cnt` by one. `rd_allowed` is 1 exactly while the bank is owned and `byte_cnt` is not 0.
- R6: A `cpu_rd` strobe while `byte_cnt` is 0 makes `rd_data` 0 and changes no other output.
- R7: A `cpu_release` strobe while `own_flag` is 1 frees the bank and clears `own_flag` and `byte_cnt` on the next edge. In two-bank mode the CPU view moves to the other bank. If that bank is already full, `rx_flag` and `own_flag` are set again on the following edge with the new length.
- R8: A packet that starts while the writer's bank is full is dropped. `hs_nak` pulses in the cycle after `pkt_end`, and ACK and NAK are never driven together.
- R9: With `cfg_dual_bank`=1, a second packet is accepted while the CPU holds the first. The CPU then sees the packets in arrival order.
- R10: A bank stores at most 64 bytes. Extra bytes are dropped and set the sticky `ovf_flag`, which only a `cpu_clr_ovf` strobe clears. `byte_cnt` never exceeds 64.
- R11: With `cfg_iso`=1, an `in_req` pulse while both banks are empty does two things on the next edge: `zlp_send` pulses for one cycle and `uf_flag` is set. If a bank is full, or `cfg_iso`=0, `in_req` has no effect.
- R12: A clear strobe (`cpu_clr_rx`, `cpu_clr_uf`, `cpu_clr_ovf`, `cpu_release`) aimed at a bit that is already 0 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual_bank | input | 1 | 1 selects two banks, 0 one bank |
| cfg_iso | input | 1 | Endpoint is isochronous |
| pkt_start | input | 1 | First cycle of an OUT packet |
| pkt_valid | input | 1 | `pkt_byte` carries a data byte |
| pkt_byte | input | 8 | Packet data byte |
| pkt_end | input | 1 | Packet finished (no data this cycle) |
| hs_ack | output | 1 | One-cycle ACK for a stored packet |
| hs_nak | output | 1 | One-cycle NAK for a dropped packet |
| in_req | input | 1 | IN request pulse |
| zlp_send | output | 1 | One-cycle request to send a zero-length packet |
| cpu_rx_ie | input | 1 | Receive interrupt enable |
| cpu_uf_ie | input | 1 | Underflow interrupt enable |
| cpu_clr_rx | input | 1 | Clear receive flag |
| cpu_release | input | 1 | Clear ownership bit, freeing the bank |
| cpu_clr_uf | input | 1 | Clear underflow flag |
| cpu_clr_ovf | input | 1 | Clear overflow flag |
| cpu_rd | input | 1 | Read one byte from the data port |
| rd_data | output | 8 | Byte returned by the last read |
| byte_cnt | output | 7 | Unread bytes in the owned bank |
| rd_allowed | output | 1 | Owned bank still holds unread data |
| rx_flag | output | 1 | Receive-complete flag |
| own_flag | output | 1 | CPU holds the current bank |
| uf_flag | output | 1 | Isochronous underflow flag |
| ovf_flag | output | 1 | Sticky packet-overflow flag |
| ep_irq | output | 1 | Endpoint interrupt |

## Verification
The assertions check the following on every cycle:
- ACK and NAK are never driven together.
- An ACK is followed by ownership.
- The interrupt always has an active source.
- Clearing the receive flag never drops ownership.
- Each allowed read lowers the count by exactly one, and an empty owned bank stays empty.
- Release drops ownership.
- The count stays within the bank size.
- A zero-length packet is always paired with the underflow flag.

Only the bench scenarios can show the rest:
- The byte values and their order across two banks.
- The re-raise of the receive flag right after a release finds a full bank.
- Truncation of a 70-byte packet.
- NAK only when every configured bank is full.
- The no-effect cases for clear strobes and for IN requests on a non-isochronous or non-empty endpoint.

// File: rtl/ep_rxb_pkg.sv
package ep_rxb_pkg;

   // Bus-side writer states
   typedef enum logic [1:0] {
      WR_IDLE  = 2'd0,
      WR_STORE = 2'd1,
      WR_DROP  = 2'd2
   } wr_state_t;

   localparam int NUM_BANKS = 2;

   // One-hot select for a bank pointer
   function automatic logic [NUM_BANKS-1:0] bank_sel(input logic ptr);
      return ptr ? 2'b10 : 2'b01;
   endfunction

   // Next bank pointer: alternate when two banks are in use
   function automatic logic next_ptr(input logic ptr, input logic dual);
      return dual ? ~ptr : 1'b0;
   endfunction

endpackage

// File: rtl/ep_rxb_bank.sv
module ep_rxb_bank #(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          mark_full,
   input  logic [CW-1:0] mark_len,
   input  logic          mark_free,
   output logic          full,
   output logic [CW-1:0] len
);

   logic [DW-1:0] mem [DEPTH];

   // Storage array: written by the bus side only while the bank is free
   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];

   // Fill state and stored length
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         len  <= '0;
      end else if (mark_full) begin
         full <= 1'b1;
         len  <= mark_len;
      end else if (mark_free) begin
         full <= 1'b0;
         len  <= '0;
      end
   end

endmodule

// File: rtl/ep_rxb_writer.sv
module ep_rxb_writer
   import ep_rxb_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 dual_en,
   input  logic                 pkt_start,
   input  logic                 pkt_valid,
   input  logic [DW-1:0]        pkt_byte,
   input  logic                 pkt_end,
   input  logic [NUM_BANKS-1:0] bank_full,
   output logic                 wr_en,
   output logic [AW-1:0]        wr_addr,
   output logic [DW-1:0]        wr_data,
   output logic                 wr_bank,
   output logic [NUM_BANKS-1:0] mark_full,
   output logic [CW-1:0]        mark_len,
   output logic                 ack,
   output logic                 nak,
   output logic                 ovf_evt
);

   wr_state_t     st_q;
   logic          wptr_q;
   logic [CW-1:0] wcnt_q;
   logic          ack_q, nak_q;
   logic          room;
   logic          data_beat;

   assign room      = (wcnt_q < CW'(DEPTH));
   assign data_beat = (st_q == WR_STORE) && pkt_valid && !pkt_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= WR_IDLE;
         wptr_q <= 1'b0;
         wcnt_q <= '0;
         ack_q  <= 1'b0;
         nak_q  <= 1'b0;
      end else begin
         ack_q <= 1'b0;
         nak_q <= 1'b0;
         case (st_q)
            WR_IDLE: begin
               if (pkt_start) begin
                  st_q   <= bank_full[wptr_q] ? WR_DROP : WR_STORE;
                  wcnt_q <= '0;
               end
            end
            WR_STORE: begin
               if (pkt_end) begin
                  ack_q  <= 1'b1;
                  st_q   <= WR_IDLE;
                  wptr_q <= next_ptr(wptr_q, dual_en);
               end else if (pkt_valid && room) begin
                  wcnt_q <= wcnt_q + CW'(1);
               end
            end
            WR_DROP: begin
               if (pkt_end) begin
                  nak_q <= 1'b1;
                  st_q  <= WR_IDLE;
               end
            end
            default: st_q <= WR_IDLE;
         endcase
      end
   end

   assign wr_en     = data_beat && room;
   assign ovf_evt   = data_beat && !room;
   assign wr_addr   = wcnt_q[AW-1:0];
   assign wr_data   = pkt_byte;
   assign wr_bank   = wptr_q;
   assign mark_full = ((st_q == WR_STORE) && pkt_end) ? bank_sel(wptr_q) : '0;
   assign mark_len  = wcnt_q;
   assign ack       = ack_q;
   assign nak       = nak_q;

endmodule

// File: rtl/ep_rxb_reader.sv
module ep_rxb_reader
   import ep_rxb_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          dual_en,
   input  logic [NUM_BANKS-1:0]          bank_full,
   input  logic [NUM_BANKS-1:0][CW-1:0]  bank_len,
   input  logic [NUM_BANKS-1:0][DW-1:0]  bank_q,
   input  logic                          cpu_clr_rx,
   input  logic                          cpu_release,
   input  logic                          cpu_rd,
   output logic [AW-1:0]                 rd_idx,
   output logic [NUM_BANKS-1:0]          mark_free,
   output logic                          own,
   output logic                          rx,
   output logic [CW-1:0]                 cnt,
   output logic [DW-1:0]                 rdata
);

   logic          rptr_q;
   logic          own_q, rx_q;
   logic [CW-1:0] cnt_q;
   logic [AW-1:0] idx_q;
   logic [DW-1:0] rdat_q;
   logic          present, release_ok, take;

   // Hand a filled bank to the CPU when none is held
   assign present    = !own_q && bank_full[rptr_q];
   assign release_ok = own_q && cpu_release;
   assign take       = cpu_rd && own_q && !cpu_release && (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_q <= 1'b0;
         own_q  <= 1'b0;
         rx_q   <= 1'b0;
         cnt_q  <= '0;
         idx_q  <= '0;
         rdat_q <= '0;
      end else begin
         if (present) begin
            own_q <= 1'b1;
            cnt_q <= bank_len[rptr_q];
            idx_q <= '0;
         end else if (release_ok) begin
            own_q  <= 1'b0;
            cnt_q  <= '0;
            idx_q  <= '0;
            rptr_q <= next_ptr(rptr_q, dual_en);
         end else if (take) begin
            cnt_q <= cnt_q - CW'(1);
            idx_q <= idx_q + AW'(1);
         end

         if (cpu_rd) rdat_q <= take ? bank_q[rptr_q] : '0;

         if (present)         rx_q <= 1'b1;
         else if (cpu_clr_rx) rx_q <= 1'b0;
      end
   end

   assign rd_idx    = idx_q;
   assign mark_free = release_ok ? bank_sel(rptr_q) : '0;
   assign own       = own_q;
   assign rx        = rx_q;
   assign cnt       = cnt_q;
   assign rdata     = rdat_q;

endmodule

// File: rtl/ep_rxb_ctrl.sv
module ep_rxb_ctrl
   import ep_rxb_pkg::*;
#(
   parameter int DW           = 8,
   parameter int DEPTH        = 64,
   parameter bit DUAL_CAPABLE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_dual_bank,
   input  logic                       cfg_iso,
   input  logic                       pkt_start,
   input  logic                       pkt_valid,
   input  logic [DW-1:0]              pkt_byte,
   input  logic                       pkt_end,
   output logic                       hs_ack,
   output logic                       hs_nak,
   input  logic                       in_req,
   output logic                       zlp_send,
   input  logic                       cpu_rx_ie,
   input  logic                       cpu_uf_ie,
   input  logic                       cpu_clr_rx,
   input  logic                       cpu_release,
   input  logic                       cpu_clr_uf,
   input  logic                       cpu_clr_ovf,
   input  logic                       cpu_rd,
   output logic [DW-1:0]              rd_data,
   output logic [$clog2(DEPTH+1)-1:0] byte_cnt,
   output logic                       rd_allowed,
   output logic                       rx_flag,
   output logic                       own_flag,
   output logic                       uf_flag,
   output logic                       ovf_flag,
   output logic                       ep_irq
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("ep_rxb_ctrl: DEPTH must be at least 2");
   end
   if (DW < 1) begin : g_bad_width
      $error("ep_rxb_ctrl: DW must be at least 1");
   end

   logic                          dual_en;
   logic [NUM_BANKS-1:0]          bank_full;
   logic [NUM_BANKS-1:0][CW-1:0]  bank_len;
   logic [NUM_BANKS-1:0][DW-1:0]  bank_q;
   logic [NUM_BANKS-1:0]          set_full, set_free;
   logic                          w_en, w_bank, ovf_evt;
   logic [AW-1:0]                 w_addr, r_idx;
   logic [DW-1:0]                 w_data;
   logic [CW-1:0]                 w_len;
   logic                          uf_q, zlp_q, ovf_q;
   logic                          starve;

   // Variant: single-bank build ignores the mode input
   if (DUAL_CAPABLE) begin : g_dual
      assign dual_en = cfg_dual_bank;
   end else begin : g_single
      assign dual_en = cfg_dual_bank & 1'b0;
   end

   ep_rxb_writer #(.DW(DW), .DEPTH(DEPTH)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .dual_en   (dual_en),
      .pkt_start (pkt_start),
      .pkt_valid (pkt_valid),
      .pkt_byte  (pkt_byte),
      .pkt_end   (pkt_end),
      .bank_full (bank_full),
      .wr_en     (w_en),
      .wr_addr   (w_addr),
      .wr_data   (w_data),
      .wr_bank   (w_bank),
      .mark_full (set_full),
      .mark_len  (w_len),
      .ack       (hs_ack),
      .nak       (hs_nak),
      .ovf_evt   (ovf_evt)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      ep_rxb_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (w_en && (w_bank == 1'(b))),
         .wr_addr   (w_addr),
         .wr_data   (w_data),
         .rd_addr   (r_idx),
         .rd_data   (bank_q[b]),
         .mark_full (set_full[b]),
         .mark_len  (w_len),
         .mark_free (set_free[b]),
         .full      (bank_full[b]),
         .len       (bank_len[b])
      );
   end

   ep_rxb_reader #(.DW(DW), .DEPTH(DEPTH)) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .dual_en     (dual_en),
      .bank_full   (bank_full),
      .bank_len    (bank_len),
      .bank_q      (bank_q),
      .cpu_clr_rx  (cpu_clr_rx),
      .cpu_release (cpu_release),
      .cpu_rd      (cpu_rd),
      .rd_idx      (r_idx),
      .mark_free   (set_free),
      .own         (own_flag),
      .rx          (rx_flag),
      .cnt         (byte_cnt),
      .rdata       (rd_data)
   );

   // Isochronous IN underflow and sticky overflow
   assign starve = in_req && cfg_iso && (bank_full == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uf_q  <= 1'b0;
         zlp_q <= 1'b0;
         ovf_q <= 1'b0;
      end else begin
         zlp_q <= starve;
         if (starve)          uf_q <= 1'b1;
         else if (cpu_clr_uf) uf_q <= 1'b0;
         if (ovf_evt)          ovf_q <= 1'b1;
         else if (cpu_clr_ovf) ovf_q <= 1'b0;
      end
   end

   assign zlp_send   = zlp_q;
   assign uf_flag    = uf_q;
   assign ovf_flag   = ovf_q;
   assign rd_allowed = own_flag && (byte_cnt != '0);
   assign ep_irq     = (rx_flag && cpu_rx_ie) || (uf_q && cpu_uf_ie);

endmodule

// File: rtl/ep_rxb_ctrl_chk.sv
module ep_rxb_ctrl_chk #(
   parameter int DEPTH = 64,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          hs_ack,
   input logic          hs_nak,
   input logic          cpu_release,
   input logic          cpu_clr_rx,
   input logic          cpu_rd,
   input logic          rd_allowed,
   input logic [CW-1:0] byte_cnt,
   input logic          own_flag,
   input logic          rx_flag,
   input logic          uf_flag,
   input logic          zlp_send,
   input logic          ep_irq
);

   p_ack_owns_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_ack && !cpu_release) |=> own_flag);

   p_irq_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ep_irq |-> (rx_flag || uf_flag));

   p_clr_keeps_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (own_flag && cpu_clr_rx && !cpu_release) |=> own_flag);

   p_read_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && rd_allowed && !cpu_release) |=> (byte_cnt == ($past(byte_cnt) - CW'(1))));

   p_empty_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (own_flag && (byte_cnt == '0) && !cpu_release) |=> (byte_cnt == '0));

   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (own_flag && cpu_release) |=> !own_flag);

   p_ack_nak_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_ack && hs_nak));

   p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      byte_cnt <= CW'(DEPTH));

   p_zlp_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      zlp_send |-> uf_flag);

endmodule

bind ep_rxb_ctrl ep_rxb_ctrl_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/ep_rxb_ctrl_test.sv
module ep_rxb_ctrl_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_dual_bank = 1'b0, cfg_iso = 1'b0;
   logic pkt_start = 1'b0, pkt_valid = 1'b0, pkt_end = 1'b0;
   logic [7:0] pkt_byte = 8'h00;
   logic in_req = 1'b0;
   logic cpu_rx_ie = 1'b0, cpu_uf_ie = 1'b0;
   logic cpu_clr_rx = 1'b0, cpu_release = 1'b0, cpu_clr_uf = 1'b0, cpu_clr_ovf = 1'b0;
   logic cpu_rd = 1'b0;
   logic hs_ack, hs_nak, zlp_send, rd_allowed, rx_flag, own_flag, uf_flag, ovf_flag, ep_irq;
   logic [7:0] rd_data;
   logic [6:0] byte_cnt;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit cmp_en = 1'b0;

   always #10 clk = ~clk;

   ep_rxb_ctrl uut (.*);

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   byte unsigned bq0[$], bq1[$], wq[$], rq[$];
   bit m_full0 = 0, m_full1 = 0, m_wptr = 0, m_rptr = 0;
   int m_wst = 0;
   bit m_own = 0, m_rx = 0, m_uf = 0, m_ovf = 0, e_ack = 0, e_nak = 0, e_zlp = 0;
   int e_rd = 0;

   always @(posedge clk) begin
      bit of0, of1, oown, ocur, ovfset, pres;
      if (!rst_n) begin
         bq0.delete(); bq1.delete(); wq.delete(); rq.delete();
         m_full0 = 0; m_full1 = 0; m_wptr = 0; m_rptr = 0; m_wst = 0;
         m_own = 0; m_rx = 0; m_uf = 0; m_ovf = 0;
         e_ack = 0; e_nak = 0; e_zlp = 0; e_rd = 0;
      end else begin
         of0 = m_full0; of1 = m_full1; oown = m_own;
         e_ack = 0; e_nak = 0; e_zlp = 0; ovfset = 0;
         // bus side
         case (m_wst)
            0: if (pkt_start) begin
                  if (!(m_wptr ? of1 : of0)) begin m_wst = 1; wq.delete(); end
                  else m_wst = 2;
               end
            1: if (pkt_end) begin
                  if (m_wptr) begin bq1 = wq; m_full1 = 1; end
                  else begin bq0 = wq; m_full0 = 1; end
                  e_ack = 1; m_wst = 0;
                  m_wptr = cfg_dual_bank ? !m_wptr : 1'b0;
               end else if (pkt_valid) begin
                  if (wq.size() < 64) wq.push_back(pkt_byte);
                  else ovfset = 1;
               end
            default: if (pkt_end) begin e_nak = 1; m_wst = 0; end
         endcase
         // cpu side
         ocur = m_rptr ? of1 : of0;
         pres = !oown && ocur;
         if (pres) begin
            m_own = 1;
            rq = m_rptr ? bq1 : bq0;
         end else if (oown && cpu_release) begin
            if (m_rptr) m_full1 = 0; else m_full0 = 0;
            m_own = 0; rq.delete();
            m_rptr = cfg_dual_bank ? !m_rptr : 1'b0;
         end
         if (cpu_rd) begin
            if (oown && !cpu_release && rq.size() > 0) e_rd = rq.pop_front();
            else e_rd = 0;
         end
         if (pres) m_rx = 1; else if (cpu_clr_rx) m_rx = 0;
         if (in_req && cfg_iso && !of0 && !of1) begin e_zlp = 1; m_uf = 1; end
         else if (cpu_clr_uf) m_uf = 0;
         if (ovfset) m_ovf = 1; else if (cpu_clr_ovf) m_ovf = 0;
      end
   end

   // every-cycle comparison, settled well after the falling edge
   always @(negedge clk) begin
      #2;
      if (cmp_en && rst_n) begin
         chk("R2", "hs_ack", int'(hs_ack), int'(e_ack));
         chk("R8", "hs_nak", int'(hs_nak), int'(e_nak));
         chk("R2", "rx_flag", int'(rx_flag), int'(m_rx));
         chk("R7", "own_flag", int'(own_flag), int'(m_own));
         chk("R5", "byte_cnt", int'(byte_cnt), rq.size());
         chk("R5", "rd_allowed", int'(rd_allowed), int'(m_own && rq.size() > 0));
         chk("R5", "rd_data", int'(rd_data), e_rd);
         chk("R3", "ep_irq", int'(ep_irq), int'((m_rx && cpu_rx_ie) || (m_uf && cpu_uf_ie)));
         chk("R11", "zlp_send", int'(zlp_send), int'(e_zlp));
         chk("R11", "uf_flag", int'(uf_flag), int'(m_uf));
         chk("R10", "ovf_flag", int'(ovf_flag), int'(m_ovf));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(negedge clk);
   endtask

   task automatic send_pkt(int n, int base);
      @(negedge clk) pkt_start = 1'b1;
      @(negedge clk) pkt_start = 1'b0;
      for (int i = 0; i < n; i++) begin
         pkt_valid = 1'b1;
         pkt_byte  = 8'(base + i);
         @(negedge clk);
      end
      pkt_valid = 1'b0;
      pkt_end   = 1'b1;
      @(negedge clk) pkt_end = 1'b0;
   endtask

   task automatic rd_byte();
      @(negedge clk) cpu_rd = 1'b1;
      @(negedge clk) cpu_rd = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      do_reset();
      cmp_en = 1'b1;
      chk("R1", "rx_flag", int'(rx_flag), 0);
      chk("R1", "own_flag", int'(own_flag), 0);
      chk("R1", "byte_cnt", int'(byte_cnt), 0);
      chk("R1", "rd_allowed", int'(rd_allowed), 0);
      chk("R1", "ep_irq", int'(ep_irq), 0);
      chk("R1", "uf_flag", int'(uf_flag), 0);
      chk("R1", "ovf_flag", int'(ovf_flag), 0);
      chk("R1", "hs_ack", int'(hs_ack), 0);

      // single bank: store, acknowledge, read out
      @(negedge clk) cpu_rx_ie = 1'b1;
      send_pkt(5, 8'h10);
      chk("R2", "ack pulse", int'(hs_ack), 1);
      tick();
      chk("R2", "rx set", int'(rx_flag), 1);
      chk("R2", "own set", int'(own_flag), 1);
      chk("R2", "length", int'(byte_cnt), 5);
      chk("R3", "irq on rx", int'(ep_irq), 1);
      @(negedge clk) cpu_clr_rx = 1'b1;
      @(negedge clk) cpu_clr_rx = 1'b0;
      chk("R4", "rx cleared", int'(rx_flag), 0);
      chk("R4", "own kept", int'(own_flag), 1);
      chk("R4", "count kept", int'(byte_cnt), 5);
      chk("R3", "irq off", int'(ep_irq), 0);
      for (int i = 0; i < 5; i++) begin
         rd_byte();
         chk("R5", "data", int'(rd_data), 8'h10 + i);
         chk("R5", "count", int'(byte_cnt), 4 - i);
      end
      chk("R5", "rd_allowed low", int'(rd_allowed), 0);
      rd_byte();
      chk("R6", "empty read data", int'(rd_data), 0);
      chk("R6", "empty read count", int'(byte_cnt), 0);
      chk("R6", "empty read own", int'(own_flag), 1);

      // R8: bank held, new packet refused
      send_pkt(2, 8'h40);
      chk("R8", "nak pulse", int'(hs_nak), 1);
      chk("R8", "no ack", int'(hs_ack), 0);
      @(negedge clk) cpu_release = 1'b1;
      @(negedge clk) cpu_release = 1'b0;
      chk("R7", "own released", int'(own_flag), 0);
      tick();
      chk("R7", "no stale bank", int'(own_flag), 0);

      // R12: clear strobes on clear bits
      @(negedge clk) begin
         cpu_clr_rx = 1'b1; cpu_clr_uf = 1'b1; cpu_clr_ovf = 1'b1; cpu_release = 1'b1;
      end
      @(negedge clk) begin
         cpu_clr_rx = 1'b0; cpu_clr_uf = 1'b0; cpu_clr_ovf = 1'b0; cpu_release = 1'b0;
      end
      chk("R12", "rx", int'(rx_flag), 0);
      chk("R12", "own", int'(own_flag), 0);
      chk("R12", "uf", int'(uf_flag), 0);
      chk("R12", "ovf", int'(ovf_flag), 0);
      chk("R12", "count", int'(byte_cnt), 0);

      // R10: oversize packet
      send_pkt(70, 0);
      chk("R10", "ack oversize", int'(hs_ack), 1);
      chk("R10", "ovf set", int'(ovf_flag), 1);
      tick();
      chk("R10", "truncated", int'(byte_cnt), 64);
      rd_byte();
      chk("R10", "first byte", int'(rd_data), 0);
      @(negedge clk) cpu_release = 1'b1;
      @(negedge clk) cpu_release = 1'b0;
      chk("R10", "ovf sticky", int'(ovf_flag), 1);
      @(negedge clk) cpu_clr_ovf = 1'b1;
      @(negedge clk) cpu_clr_ovf = 1'b0;
      chk("R10", "ovf cleared", int'(ovf_flag), 0);

      // two banks
      cmp_en = 1'b0;
      cfg_dual_bank = 1'b1;
      do_reset();
      cmp_en = 1'b1;
      send_pkt(3, 8'h20);
      chk("R9", "ack first", int'(hs_ack), 1);
      send_pkt(4, 8'h30);
      chk("R9", "ack second", int'(hs_ack), 1);
      send_pkt(1, 8'h70);
      chk("R8", "nak both full", int'(hs_nak), 1);
      tick();
      chk("R9", "first length", int'(byte_cnt), 3);
      for (int i = 0; i < 3; i++) begin
         rd_byte();
         chk("R9", "first data", int'(rd_data), 8'h20 + i);
      end
      @(negedge clk) cpu_clr_rx = 1'b1;
      @(negedge clk) cpu_clr_rx = 1'b0;
      @(negedge clk) cpu_release = 1'b1;
      @(negedge clk) cpu_release = 1'b0;
      chk("R7", "released", int'(own_flag), 0);
      tick();
      chk("R7", "rx again", int'(rx_flag), 1);
      chk("R7", "own again", int'(own_flag), 1);
      chk("R7", "second length", int'(byte_cnt), 4);
      rd_byte();
      chk("R9", "second data", int'(rd_data), 8'h30);
      @(negedge clk) begin cpu_release = 1'b1; cpu_clr_rx = 1'b1; end
      @(negedge clk) begin cpu_release = 1'b0; cpu_clr_rx = 1'b0; end
      tick();
      chk("R7", "all drained", int'(own_flag), 0);

      // R11: isochronous underflow
      @(negedge clk) begin cfg_iso = 1'b1; cpu_uf_ie = 1'b1; cpu_rx_ie = 1'b0; end
      @(negedge clk) in_req = 1'b1;
      @(negedge clk) in_req = 1'b0;
      chk("R11", "zlp pulse", int'(zlp_send), 1);
      chk("R11", "uf set", int'(uf_flag), 1);
      chk("R3", "irq on uf", int'(ep_irq), 1);
      tick();
      chk("R11", "zlp one cycle", int'(zlp_send), 0);
      cpu_uf_ie = 1'b0;
      #1;
      chk("R3", "uf masked", int'(ep_irq), 0);
      @(negedge clk) cpu_clr_uf = 1'b1;
      @(negedge clk) cpu_clr_uf = 1'b0;
      chk("R11", "uf cleared", int'(uf_flag), 0);
      send_pkt(2, 8'h55);
      tick();
      @(negedge clk) in_req = 1'b1;
      @(negedge clk) in_req = 1'b0;
      chk("R11", "no zlp with data", int'(zlp_send), 0);
      chk("R11", "no uf with data", int'(uf_flag), 0);
      @(negedge clk) cpu_release = 1'b1;
      @(negedge clk) begin cpu_release = 1'b0; cfg_iso = 1'b0; end
      @(negedge clk) in_req = 1'b1;
      @(negedge clk) in_req = 1'b0;
      chk("R11", "no zlp non-iso", int'(zlp_send), 0);
      chk("R11", "no uf non-iso", int'(uf_flag), 0);

      repeat (3) tick();
      finish_run();
   end

endmodule